// File: doc/BRIEF.md
# Order Index Lookup Stage with Read-Ahead

This block sits in front of an order-book engine. It turns a wide order identifier into a compact order index by using a direct-mapped table kept in a slow external memory. Each table word holds an index and a valid flag. An insert writes the index with the flag set. A delete reads the old word and then clears it. An update, or any other lookup, only reads. The block sends these operations to the memory through a single request port. Read data comes back in request order after a fixed delay.

Each accepted command takes a slot in an internal record queue as soon as it is accepted. The memory read is issued in the same cycle. This lets a new lookup start while earlier results are still in flight or waiting at the output. The execute side pulls finished records (opcode, identifier, index, hit flag) from the head of the queue with a valid/ready handshake. Records always leave in command order. Command acceptance stalls when the queue has no free slot, so a command is never dropped. Because every outstanding read owns a queue slot, a returning response always has somewhere to go.

Top module: `oid_lookup`

## Requirements
- R1: An insert (`cmd_op` = 0) issues one memory write of {1'b1, `cmd_idx`} to address `cmd_id` in its accept cycle. Its record carries op 0, the same identifier, `cmd_idx` and hit = 1.
- R2: An update (`cmd_op` = 1), or the unassigned code 3, issues one memory read at `cmd_id`. If the returned valid bit (the word's MSB) is set, the record carries the stored index and hit = 1.
- R3: A lookup that returns a word with the valid bit clear produces a record with hit = 0 and index 0.
- R4: A delete (`cmd_op` = 2) reads `cmd_id` in its accept cycle and writes {1'b0, 0} to the same address in the next cycle. `cmd_ready` is low during that write cycle. The record reports the old index and valid bit (index 0 if invalid), and later lookups of that identifier miss.
- R5: Records leave in acceptance order. A record offered while `out_ready` is low stays unchanged until it is taken.
- R6: When DEPTH records are held, `cmd_ready` stays low and no memory request is issued. Every stalled command is accepted later and produces its record.
- R7: With free queue space and no delete write pending, lookups are accepted in consecutive cycles, each before earlier read responses have returned.
- R8: A lookup accepted in the cycle right after an insert to the same identifier returns the newly written index.
- R9: Read requests in flight never exceed the records held, so a response never arrives with no read pending.
- R10: After reset `cmd_ready` is 1, `out_valid` is 0 and, with `cmd_valid` low, `mem_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 2 | 0 insert, 1 update, 2 delete, 3 lookup |
| cmd_id | input | ID_W | Order identifier, table address |
| cmd_idx | input | IDX_W | Index written by an insert |
| mem_req | output | 1 | Memory request strobe |
| mem_wr | output | 1 | Request is a write |
| mem_addr | output | ID_W | Table address |
| mem_wdata | output | IDX_W+1 | {valid, index} to write |
| mem_rvalid | input | 1 | Read response strobe, in request order |
| mem_rdata | input | IDX_W+1 | {valid, index} read |
| out_valid | output | 1 | Finished record at the head |
| out_ready | input | 1 | Execute side takes the record |
| out_op | output | 2 | Opcode of the record |
| out_id | output | ID_W | Identifier of the record |
| out_idx | output | IDX_W | Index found or written |
| out_hit | output | 1 | Entry was valid |

## Verification
The bench builds the block with a 4-bit identifier, a 5-bit index, a queue depth of 4 and a modelled memory read latency of 3 cycles. With 16 identifiers, every table entry can be inserted, looked up, deleted and looked up again in one sweep. The shallow queue fills within a few commands, so the full-queue stall and the back-to-back read overlap can both be observed directly at the ports. The expected records come from a bench-side shadow of the table that is updated at each accept.

// File: rtl/oid_lookup.sv
module oid_lookup #(
  parameter int ID_W  = 32,
  parameter int IDX_W = 20,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [ID_W-1:0]  cmd_id,
  input  logic [IDX_W-1:0] cmd_idx,
  output logic             mem_req,
  output logic             mem_wr,
  output logic [ID_W-1:0]  mem_addr,
  output logic [IDX_W:0]   mem_wdata,
  input  logic             mem_rvalid,
  input  logic [IDX_W:0]   mem_rdata,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_op,
  output logic [ID_W-1:0]  out_id,
  output logic [IDX_W-1:0] out_idx,
  output logic             out_hit
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);
  localparam logic [1:0] OP_INS = 2'd0;
  localparam logic [1:0] OP_DEL = 2'd2;

  logic [1:0]       q_op  [DEPTH];
  logic [ID_W-1:0]  q_id  [DEPTH];
  logic [IDX_W-1:0] q_idx [DEPTH];
  logic             q_hit [DEPTH];
  logic             q_done[DEPTH];
  logic [AW-1:0]    pq    [DEPTH];

  logic [AW-1:0]   wp, rp, pwp, prp;
  logic [AW:0]     cnt, pend_n;
  logic            del_wr;
  logic [ID_W-1:0] del_addr;

  logic acc, pop, is_ins, is_del, is_rd;

  assign is_ins    = cmd_op == OP_INS;
  assign is_del    = cmd_op == OP_DEL;
  assign cmd_ready = !del_wr && (cnt != FULL);
  assign acc       = cmd_valid && cmd_ready;
  assign is_rd     = acc && !is_ins;
  assign out_valid = (cnt != '0) && q_done[rp];
  assign pop       = out_valid && out_ready;

  assign mem_req   = acc || del_wr;
  assign mem_wr    = del_wr || (acc && is_ins);
  assign mem_addr  = del_wr ? del_addr : cmd_id;
  assign mem_wdata = del_wr ? '0 : {1'b1, cmd_idx};

  assign out_op  = q_op[rp];
  assign out_id  = q_id[rp];
  assign out_idx = q_idx[rp];
  assign out_hit = q_hit[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; pwp <= '0; prp <= '0;
      cnt <= '0; pend_n <= '0;
      del_wr <= 1'b0; del_addr <= '0;
    end else begin
      if (acc) wp <= wp + 1'b1;
      if (pop) rp <= rp + 1'b1;
      if (is_rd) pwp <= pwp + 1'b1;
      if (mem_rvalid) prp <= prp + 1'b1;
      cnt <= cnt + (AW+1)'(acc) - (AW+1)'(pop);
      pend_n <= pend_n + (AW+1)'(is_rd) - (AW+1)'(mem_rvalid);
      del_wr <= acc && is_del;
      if (acc && is_del) del_addr <= cmd_id;
    end
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      q_op[wp]   <= cmd_op;
      q_id[wp]   <= cmd_id;
      q_idx[wp]  <= is_ins ? cmd_idx : '0;
      q_hit[wp]  <= is_ins;
      q_done[wp] <= is_ins;
    end
    if (is_rd) pq[pwp] <= wp;
    if (mem_rvalid) begin
      q_idx[pq[prp]]  <= mem_rdata[IDX_W] ? mem_rdata[IDX_W-1:0] : '0;
      q_hit[pq[prp]]  <= mem_rdata[IDX_W];
      q_done[pq[prp]] <= 1'b1;
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
  p_full_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == FULL && !del_wr) |-> !mem_req);
  p_rsp_expected_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> pend_n != '0);
  p_pend_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_n <= cnt);
  p_del_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_del) |=> (mem_req && mem_wr && !mem_wdata[IDX_W]
                         && mem_addr == $past(cmd_id) && !cmd_ready));
  p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_id)
                                   && $stable(out_idx) && $stable(out_op)));
  p_miss_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> out_idx == '0);
endmodule

// File: tb/tb_oid_lookup.sv
module tb_oid_lookup;
  localparam int ID_W = 4, IDX_W = 5, DEPTH = 4, LAT = 3, NID = 16;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, out_ready = 0;
  logic [1:0] cmd_op = 0;
  logic [ID_W-1:0] cmd_id = 0;
  logic [IDX_W-1:0] cmd_idx = 0;
  logic mem_req, mem_wr, mem_rvalid, cmd_ready, out_valid, out_hit;
  logic [ID_W-1:0] mem_addr, out_id;
  logic [IDX_W:0] mem_wdata, mem_rdata;
  logic [1:0] out_op;
  logic [IDX_W-1:0] out_idx;

  always #4 clk = ~clk;

  oid_lookup #(.ID_W(ID_W), .IDX_W(IDX_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_id(cmd_id), .cmd_idx(cmd_idx),
    .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op),
    .out_id(out_id), .out_idx(out_idx), .out_hit(out_hit));

  logic [IDX_W:0] tbl[NID];
  logic [LAT-1:0] pv;
  logic [IDX_W:0] pd[LAT];
  always @(posedge clk) begin
    if (!rst_n) begin
      pv <= '0;
      for (int i = 0; i < NID; i++) tbl[i] <= '0;
    end else begin
      pv <= {pv[LAT-2:0], mem_req & ~mem_wr};
      pd[0] <= tbl[mem_addr];
      for (int i = 1; i < LAT; i++) pd[i] <= pd[i-1];
      if (mem_req && mem_wr) tbl[mem_addr] <= mem_wdata;
    end
  end
  assign mem_rvalid = pv[LAT-1];
  assign mem_rdata  = pd[LAT-1];

  int total = 0, bad = 0, cyc = 0, acc_cyc = 0;
  logic stall_out = 0, done = 0;
  logic ref_v[NID];
  logic [IDX_W-1:0] ref_i[NID];
  logic [31:0] exp_q[$];
  string tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk); #1;
      out_ready = !stall_out;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(0, "R5 unexpected record", {out_op, out_id}, 0);
        else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(out_id == e[ID_W+IDX_W:IDX_W+1], "R5 order", out_id, e[ID_W+IDX_W:IDX_W+1]);
          chk({out_op, out_idx, out_hit} == {e[ID_W+IDX_W+2:ID_W+IDX_W+1], e[IDX_W:0]},
              t, {out_op, out_idx, out_hit},
              {e[ID_W+IDX_W+2:ID_W+IDX_W+1], e[IDX_W:0]});
        end
      end
    end
  end

  task automatic send(input logic [1:0] op, input int id, input int idx, input string force_tag);
    string t;
    logic [IDX_W-1:0] ei;
    logic eh;
    cmd_op = op; cmd_id = ID_W'(id); cmd_idx = IDX_W'(idx); cmd_valid = 1;
    forever begin
      if (cmd_ready) begin
        @(posedge clk);
        acc_cyc = cyc;
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    cmd_valid = 0;
    if (op == 2'd0) begin
      ei = IDX_W'(idx); eh = 1; t = "R1";
      ref_v[id] = 1; ref_i[id] = IDX_W'(idx);
    end else begin
      eh = ref_v[id]; ei = eh ? ref_i[id] : '0;
      t = (op == 2'd2) ? "R4" : (eh ? "R2" : "R3");
      if (op == 2'd2) ref_v[id] = 0;
    end
    if (force_tag != "") t = force_tag;
    exp_q.push_back({21'd0, op, ID_W'(id), ei, eh});
    tag_q.push_back(t);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NID; i++) begin ref_v[i] = 0; ref_i[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready == 1, "R10 cmd_ready", cmd_ready, 1);
    chk(out_valid == 0, "R10 out_valid", out_valid, 0);
    chk(mem_req == 0, "R10 mem_req", mem_req, 0);

    for (int id = 0; id < NID; id++) begin
      send(2'd0, id, (id * 5 + 3) % 32, "");
      if (id % 4 == 0) send(2'd1, id, 0, "R8");
    end
    for (int id = 0; id < NID; id++) send((id % 5 == 2) ? 2'd3 : 2'd1, id, 0, "");
    for (int id = 1; id < NID; id += 2) send(2'd2, id, 0, "");
    send(2'd2, 2, 0, "");
    send(2'd1, 2, 0, "R4");
    for (int id = 0; id < NID; id++) send(2'd1, id, 0, "");
    send(2'd2, 3, 0, "");
    send(2'd0, 3, 17, "");
    send(2'd1, 3, 0, "R8");
    drain();

    begin
      int c0;
      send(2'd1, 0, 0, ""); c0 = acc_cyc;
      for (int k = 1; k < 4; k++) begin
        send(2'd1, k * 4, 0, "");
        chk(acc_cyc == c0 + k, "R7 back-to-back accept", acc_cyc - c0, k);
      end
    end
    drain();

    stall_out = 1;
    for (int k = 0; k < DEPTH; k++) send(2'd1, k, 0, "");
    repeat (8) @(negedge clk);
    chk(cmd_ready == 0, "R6 stall when full", cmd_ready, 0);
    chk(out_valid == 1, "R6 head waiting", out_valid, 1);
    chk(mem_req == 0, "R6 no request when full", mem_req, 0);
    fork
      begin repeat (5) @(negedge clk); stall_out = 0; end
      begin send(2'd1, 8, 0, ""); send(2'd0, 9, 30, ""); send(2'd1, 9, 0, "R8"); end
    join
    drain();
    chk(exp_q.size() == 0, "R6 no command lost", exp_q.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", exp_q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule